// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a logical address into a 32-bit linear address. A logical address is a 16-bit selector together with a 32-bit offset. Six segment registers each keep a hidden copy of their decoded descriptor. To load a register, the caller presents a selector. A small state machine then checks the selector against the size of the chosen descriptor table and reads the 8-byte descriptor as two 32-bit words over a plain read port. It validates the descriptor and writes the result into the hidden copy.

Once a segment is loaded, a translation request names the segment and an offset. One cycle later the unit returns either the linear address (base plus offset) or a fault with a cause code. Translation uses only the hidden copy and never touches memory. A request on a segment that is still being fetched is stalled. Requests on every other segment continue to be served.

The fetch state machine has five states. IDLE accepts a load. It goes to REJECT when the descriptor would lie past the table size, and to READ_LO otherwise. READ_LO waits for the low word and then goes to READ_HI. READ_HI waits for the high word and then goes to DECIDE. DECIDE and REJECT each last one cycle, report the load outcome, update the hidden copy and return to IDLE.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `ld_ready` is 1 and `mem_req` is 0. Every segment is unloaded, so a translation on any segment faults with cause 6.
- R2: Selector bits 15:3 are the index, bit 2 picks the table (0 = global, 1 = local) and bits 1:0 are the requested privilege. The descriptor's low word is read first, at table base + index×8, and its high word second, at +4. The address is held steady until `mem_rvalid`.
- R3: When index×8+7 is greater than the selected table limit, the load faults with cause 1 and makes no memory read.
- R4: High word bits 31:24 hold base[31:24] and low word bits 31:16 hold base[15:0]; high word bits 7:0 hold base[23:16]. Limit[15:0] sits in low word bits 15:0 and limit[19:16] in high word bits 19:16. The high word also holds G in bit 23, the reserved bit in bit 21, P in bit 15 and DPL in bits 14:13. A load with P = 0 faults with cause 2.
- R5: When P = 1 and the reserved bit (high word bit 21, descriptor bit 53) is 1, the load faults with cause 4.
- R6: When P = 1, the reserved bit is 0 and max(cpl, RPL) is greater than DPL, the load faults with cause 3. Otherwise the load succeeds, with `ld_fault` = 0 and cause 0.
- R7: A translation on a loaded segment with an offset at or below the effective limit gives `xl_ok` = 1 and `xl_lin` = base + offset, taken modulo 2^32. The result appears in the cycle after the request.
- R8: The effective limit is {limit, 0xFFF} when G = 1 and the zero-extended limit when G = 0. An offset above it gives `xl_fault` with cause 5 and `xl_lin` = 0.
- R9: A translation faults with cause 3 when max(cpl at request, RPL of the loaded selector) is greater than the cached DPL.
- R10: A failed load leaves its segment unloaded, so translations on it fault with cause 6. Other segments are not affected.
- R11: While a load is in progress, `ld_ready` is 0. A request on the segment being fetched raises `xl_stall` and produces no result. Requests on other segments are served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpl | input | 2 | Current privilege level |
| gdt_base | input | 32 | Global table base |
| gdt_limit | input | 16 | Global table last byte offset |
| ldt_base | input | 32 | Local table base |
| ldt_limit | input | 16 | Local table last byte offset |
| ld_valid | input | 1 | Load request |
| ld_seg | input | 3 | Segment register number 0..5 |
| ld_sel | input | 16 | Selector to load |
| ld_ready | output | 1 | Ready to accept a load |
| ld_done | output | 1 | Load outcome pulse |
| ld_fault | output | 1 | Load failed |
| ld_cause | output | 3 | Load fault cause |
| mem_req | output | 1 | Read request, held until data arrives |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| xl_valid | input | 1 | Translation request |
| xl_seg | input | 3 | Segment used |
| xl_off | input | 32 | Offset |
| xl_stall | output | 1 | Request not accepted, segment busy |
| xl_ok | output | 1 | Linear address valid |
| xl_fault | output | 1 | Translation fault |
| xl_cause | output | 3 | Translation fault cause |
| xl_lin | output | 32 | Linear address |

## Verification
A wrong fetch state shows up at the memory port first. A wrong or unstable `mem_addr` is visible in the very read it belongs to. A stuck state machine keeps `ld_ready` low and never pulses `ld_done`. A wrongly decoded or wrongly cached descriptor stays hidden until the next translation on that segment. That translation then shows a wrong address, a wrong boundary offset or a wrong fault cause one cycle after it is issued. For this reason the bench probes each effective-limit edge from both sides and sweeps every privilege combination.

// File: rtl/seg_pkg.sv
package seg_pkg;
    typedef enum logic [2:0] {
        C_NONE  = 3'd0,
        C_TBL   = 3'd1,
        C_NP    = 3'd2,
        C_PRIV  = 3'd3,
        C_RSVD  = 3'd4,
        C_LIMIT = 3'd5,
        C_UNLD  = 3'd6
    } cause_t;

    typedef enum logic [2:0] {
        S_IDLE, S_READ_LO, S_READ_HI, S_DECIDE, S_REJECT
    } fstate_t;

    function automatic logic [1:0] pmax(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
    import seg_pkg::*;
#(
    parameter int SW = 3,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cpl,
    input  logic [31:0]   gdt_base,
    input  logic [TW-1:0] gdt_limit,
    input  logic [31:0]   ldt_base,
    input  logic [TW-1:0] ldt_limit,
    input  logic          ld_valid,
    input  logic [SW-1:0] ld_seg,
    input  logic [15:0]   ld_sel,
    output logic          ld_ready,
    output logic          ld_done,
    output logic          ld_fault,
    output cause_t        ld_cause,
    output logic          mem_req,
    output logic [31:0]   mem_addr,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          busy,
    output logic [SW-1:0] busy_seg,
    output logic          wr_en,
    output logic          wr_ok,
    output logic [31:0]   wr_base,
    output logic [31:0]   wr_elim,
    output logic [1:0]    wr_dpl,
    output logic [1:0]    wr_rpl
);
    fstate_t       state, nxt;
    logic [15:0]   sel_q;
    logic [1:0]    cpl_q;
    logic [31:0]   tbase_q;
    logic [31:0]   lo_q, hi_q;
    logic [TW-1:0] tlim;
    logic [15:0]   last_byte;
    logic          over;
    cause_t        dcause;

    assign tlim      = ld_sel[2] ? ldt_limit : gdt_limit;
    assign last_byte = {ld_sel[15:3], 3'b111};
    assign over      = TW'(last_byte) > tlim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (ld_valid) nxt = over ? S_REJECT : S_READ_LO;
            S_READ_LO: if (mem_rvalid) nxt = S_READ_HI;
            S_READ_HI: if (mem_rvalid) nxt = S_DECIDE;
            S_DECIDE:  nxt = S_IDLE;
            S_REJECT:  nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0; cpl_q <= '0; tbase_q <= '0; lo_q <= '0; hi_q <= '0; busy_seg <= '0;
        end else begin
            if (state == S_IDLE && ld_valid) begin
                sel_q    <= ld_sel;
                cpl_q    <= cpl;
                busy_seg <= ld_seg;
                tbase_q  <= (ld_sel[2] ? ldt_base : gdt_base) + {16'd0, ld_sel[15:3], 3'b000};
            end
            if (state == S_READ_LO && mem_rvalid) lo_q <= mem_rdata;
            if (state == S_READ_HI && mem_rvalid) hi_q <= mem_rdata;
        end
    end

    always_comb begin
        if (!hi_q[15])                                     dcause = C_NP;
        else if (hi_q[21])                                 dcause = C_RSVD;
        else if (pmax(cpl_q, sel_q[1:0]) > hi_q[14:13])    dcause = C_PRIV;
        else                                               dcause = C_NONE;
    end

    always_comb begin
        ld_ready = 1'b0; ld_done = 1'b0; ld_fault = 1'b0; ld_cause = C_NONE;
        mem_req  = 1'b0; mem_addr = tbase_q; wr_en = 1'b0; wr_ok = 1'b0;
        unique case (state)
            S_IDLE:    ld_ready = 1'b1;
            S_READ_LO: mem_req  = 1'b1;
            S_READ_HI: begin mem_req = 1'b1; mem_addr = tbase_q + 32'd4; end
            S_DECIDE:  begin
                ld_done = 1'b1; wr_en = 1'b1;
                ld_cause = dcause; ld_fault = (dcause != C_NONE); wr_ok = (dcause == C_NONE);
            end
            S_REJECT:  begin ld_done = 1'b1; wr_en = 1'b1; ld_fault = 1'b1; ld_cause = C_TBL; end
            default:   ;
        endcase
    end

    assign busy    = (state != S_IDLE);
    assign wr_base = {hi_q[31:24], hi_q[7:0], lo_q[31:16]};
    assign wr_elim = hi_q[23] ? {hi_q[19:16], lo_q[15:0], 12'hFFF} : {12'd0, hi_q[19:16], lo_q[15:0]};
    assign wr_dpl  = hi_q[14:13];
    assign wr_rpl  = sel_q[1:0];

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_req) && !$past(mem_rvalid)) |-> (mem_req && $stable(mem_addr)));
    assert_hi_follows_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state == S_READ_LO) && $past(mem_rvalid)) |-> (mem_addr == $past(mem_addr) + 32'd4));
    assert_reject_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REJECT) |-> (!mem_req && ld_fault));
    assert_done_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |-> (!ld_ready && busy));
endmodule

// File: rtl/seg_translate.sv
module seg_translate
    import seg_pkg::*;
#(
    parameter int NSEG = 6,
    parameter int SW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cpl,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_seg,
    input  logic          wr_ok,
    input  logic [31:0]   wr_base,
    input  logic [31:0]   wr_elim,
    input  logic [1:0]    wr_dpl,
    input  logic [1:0]    wr_rpl,
    input  logic          busy,
    input  logic [SW-1:0] busy_seg,
    input  logic          xl_valid,
    input  logic [SW-1:0] xl_seg,
    input  logic [31:0]   xl_off,
    output logic          xl_stall,
    output logic          xl_ok,
    output logic          xl_fault,
    output cause_t        xl_cause,
    output logic [31:0]   xl_lin
);
    logic [NSEG-1:0] vld;
    logic [31:0]     base [NSEG];
    logic [31:0]     elim [NSEG];
    logic [1:0]      dpl  [NSEG];
    logic [1:0]      rpl  [NSEG];
    logic            seg_in;
    logic            take;
    cause_t          c;

    for (genvar i = 0; i < NSEG; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld[i] <= 1'b0; base[i] <= '0; elim[i] <= '0; dpl[i] <= '0; rpl[i] <= '0;
            end else if (wr_en && wr_seg == SW'(i)) begin
                vld[i]  <= wr_ok;
                base[i] <= wr_base;
                elim[i] <= wr_elim;
                dpl[i]  <= wr_dpl;
                rpl[i]  <= wr_rpl;
            end
        end
    end

    assign seg_in   = (32'(xl_seg) < NSEG);
    assign xl_stall = xl_valid && busy && (xl_seg == busy_seg);
    assign take     = xl_valid && !xl_stall;

    always_comb begin
        if (!seg_in || !vld[xl_seg])                           c = C_UNLD;
        else if (pmax(cpl, rpl[xl_seg]) > dpl[xl_seg])         c = C_PRIV;
        else if (xl_off > elim[xl_seg])                        c = C_LIMIT;
        else                                                   c = C_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xl_ok <= 1'b0; xl_fault <= 1'b0; xl_cause <= C_NONE; xl_lin <= '0;
        end else begin
            xl_ok    <= take && (c == C_NONE);
            xl_fault <= take && (c != C_NONE);
            xl_cause <= take ? c : C_NONE;
            xl_lin   <= (take && c == C_NONE) ? base[xl_seg] + xl_off : 32'd0;
        end
    end

    assert_single_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_ok && xl_fault));
    assert_result_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_ok || xl_fault) |-> $past(xl_valid));
    assert_stall_no_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xl_stall) |-> (!xl_ok && !xl_fault));
    assert_stall_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        xl_stall |-> busy);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int NSEG = 6,
    parameter int TW   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cpl,
    input  logic [31:0]   gdt_base,
    input  logic [TW-1:0] gdt_limit,
    input  logic [31:0]   ldt_base,
    input  logic [TW-1:0] ldt_limit,
    input  logic          ld_valid,
    input  logic [2:0]    ld_seg,
    input  logic [15:0]   ld_sel,
    output logic          ld_ready,
    output logic          ld_done,
    output logic          ld_fault,
    output logic [2:0]    ld_cause,
    output logic          mem_req,
    output logic [31:0]   mem_addr,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    input  logic          xl_valid,
    input  logic [2:0]    xl_seg,
    input  logic [31:0]   xl_off,
    output logic          xl_stall,
    output logic          xl_ok,
    output logic          xl_fault,
    output logic [2:0]    xl_cause,
    output logic [31:0]   xl_lin
);
    localparam int SW = 3;

    logic          busy, wr_en, wr_ok;
    logic [SW-1:0] busy_seg;
    logic [31:0]   wr_base, wr_elim;
    logic [1:0]    wr_dpl, wr_rpl;
    cause_t        lc, xc;

    seg_desc_fetch #(.SW(SW), .TW(TW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .cpl(cpl),
        .gdt_base(gdt_base), .gdt_limit(gdt_limit), .ldt_base(ldt_base), .ldt_limit(ldt_limit),
        .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel),
        .ld_ready(ld_ready), .ld_done(ld_done), .ld_fault(ld_fault), .ld_cause(lc),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .busy_seg(busy_seg), .wr_en(wr_en), .wr_ok(wr_ok),
        .wr_base(wr_base), .wr_elim(wr_elim), .wr_dpl(wr_dpl), .wr_rpl(wr_rpl)
    );

    seg_translate #(.NSEG(NSEG), .SW(SW)) u_xl (
        .clk(clk), .rst_n(rst_n), .cpl(cpl),
        .wr_en(wr_en), .wr_seg(busy_seg), .wr_ok(wr_ok), .wr_base(wr_base), .wr_elim(wr_elim),
        .wr_dpl(wr_dpl), .wr_rpl(wr_rpl), .busy(busy), .busy_seg(busy_seg),
        .xl_valid(xl_valid), .xl_seg(xl_seg), .xl_off(xl_off),
        .xl_stall(xl_stall), .xl_ok(xl_ok), .xl_fault(xl_fault), .xl_cause(xc), .xl_lin(xl_lin)
    );

    assign ld_cause = lc;
    assign xl_cause = xc;
endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
    logic clk = 0, rst_n = 0;
    always #4 clk = ~clk;

    logic [1:0]  cpl = 0;
    logic        ld_valid = 0, xl_valid = 0;
    logic [2:0]  ld_seg = 0, xl_seg = 0;
    logic [15:0] ld_sel = 0;
    logic [31:0] xl_off = 0;
    logic        ld_ready, ld_done, ld_fault, mem_req, mem_rvalid, xl_stall, xl_ok, xl_fault;
    logic [2:0]  ld_cause, xl_cause;
    logic [31:0] mem_addr, mem_rdata, xl_lin;

    seg_xlate u0 (
        .clk(clk), .rst_n(rst_n), .cpl(cpl),
        .gdt_base(32'h0), .gdt_limit(16'h002F), .ldt_base(32'h100), .ldt_limit(16'h001F),
        .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel),
        .ld_ready(ld_ready), .ld_done(ld_done), .ld_fault(ld_fault), .ld_cause(ld_cause),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .xl_valid(xl_valid), .xl_seg(xl_seg), .xl_off(xl_off),
        .xl_stall(xl_stall), .xl_ok(xl_ok), .xl_fault(xl_fault), .xl_cause(xl_cause), .xl_lin(xl_lin)
    );

    logic [31:0] mem [128];
    logic [31:0] alog [8];
    int nreads = 0;
    int cnt = 0;
    int checks = 0, errors = 0;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req && !mem_rvalid) begin
            if (cnt == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[8:2]];
                alog[nreads % 8] <= mem_addr;
                nreads <= nreads + 1;
                cnt <= 0;
            end else cnt <= cnt + 1;
        end else cnt <= 0;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l,
                                       input logic g, input logic p, input logic [1:0] d, input logic rsv);
        logic [31:0] lo, hi;
        lo = {b[15:0], l[15:0]};
        hi = {b[31:24], g, 1'b1, rsv, 1'b0, l[19:16], p, d, 1'b1, 4'b0010, b[23:16]};
        return {hi, lo};
    endfunction

    task automatic put(input int tbl, input int idx, input logic [63:0] d);
        int w;
        w = (tbl ? 64 : 0) + idx * 2;
        mem[w]   = d[31:0];
        mem[w+1] = d[63:32];
    endtask

    logic       r_fault;
    logic [2:0] r_cause;
    task automatic do_load(input logic [2:0] seg, input logic [15:0] sel);
        int n;
        @(negedge clk);
        ld_valid = 1; ld_seg = seg; ld_sel = sel;
        @(negedge clk);
        ld_valid = 0;
        n = 0;
        while (!ld_done && n < 50) begin @(negedge clk); n++; end
        r_fault = ld_fault; r_cause = ld_cause;
        @(negedge clk);
    endtask

    task automatic xlate(input logic [2:0] seg, input logic [31:0] off,
                         input string tag, input logic expok, input logic [2:0] expc, input logic [31:0] explin);
        @(negedge clk);
        xl_valid = 1; xl_seg = seg; xl_off = off;
        @(negedge clk);
        xl_valid = 0;
        check({tag, " ok"}, {31'd0, xl_ok}, {31'd0, expok});
        check({tag, " fault"}, {31'd0, xl_fault}, {31'd0, !expok});
        check({tag, " cause"}, {29'd0, xl_cause}, {29'd0, expc});
        check({tag, " lin"}, xl_lin, explin);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n0, expc;
        for (int i = 0; i < 128; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 ld_ready", {31'd0, ld_ready}, 32'd1);
        check("R1 mem_req", {31'd0, mem_req}, 32'd0);
        for (int s = 0; s < 6; s++) xlate(3'(s), 32'h0, "R1 unloaded", 0, 3'd6, 32'h0);

        // R2 R4 R7 byte granularity, global table index 1
        put(0, 1, mk(32'h12345000, 20'h00FFF, 0, 1, 2'd3, 0));
        n0 = nreads;
        do_load(3, 16'h0008);
        check("R6 load ok", {29'd0, r_fault, r_cause}, 32'd0);
        check("R2 reads", nreads - n0, 2);
        check("R2 low addr", alog[n0 % 8], 32'h08);
        check("R2 high addr", alog[(n0 + 1) % 8], 32'h0C);
        for (int k = 0; k < 4; k++)
            xlate(3, 32'(k) * 32'h555, "R7 byte span", 1, 3'd0, 32'h12345000 + 32'(k) * 32'h555);
        xlate(3, 32'h0FFF, "R8 byte edge", 1, 3'd0, 32'h12345FFF);
        xlate(3, 32'h1000, "R8 byte over", 0, 3'd5, 32'h0);

        // R8 page granularity and R7 wrap, local table index 2
        put(1, 2, mk(32'hFFFFF000, 20'h00002, 1, 1, 2'd3, 0));
        n0 = nreads;
        do_load(1, 16'h0014);
        check("R6 ldt load ok", {29'd0, r_fault, r_cause}, 32'd0);
        check("R2 ldt addr", alog[n0 % 8], 32'h110);
        check("R2 ldt addr hi", alog[(n0 + 1) % 8], 32'h114);
        xlate(1, 32'h2FFF, "R8 page edge", 1, 3'd0, 32'hFFFFF000 + 32'h2FFF);
        xlate(1, 32'h3000, "R8 page over", 0, 3'd5, 32'h0);
        xlate(1, 32'h1234, "R7 wrap", 1, 3'd0, 32'h00000234);

        // R3 table limit, no reads
        n0 = nreads;
        do_load(2, 16'h0030);
        check("R3 cause", {29'd0, r_cause}, 32'd1);
        check("R3 fault", {31'd0, r_fault}, 32'd1);
        check("R3 no read", nreads - n0, 0);
        do_load(2, 16'h0024);  // ldt index 4, limit 0x1F
        check("R3 ldt cause", {29'd0, r_cause}, 32'd1);

        // R4 not present, R10 unloaded after failure
        put(0, 2, mk(32'h1000, 20'hFFFFF, 0, 0, 2'd3, 0));
        do_load(3, 16'h0010);
        check("R4 cause", {29'd0, r_cause}, 32'd2);
        xlate(3, 32'h0, "R10 after fail", 0, 3'd6, 32'h0);
        xlate(1, 32'h0, "R10 other kept", 1, 3'd0, 32'hFFFFF000);

        // R5 reserved bit, also with privilege violation present
        put(0, 4, mk(32'h2000, 20'h00010, 0, 1, 2'd0, 1));
        cpl = 2'd3;
        do_load(4, 16'h0020);
        check("R5 cause", {29'd0, r_cause}, 32'd4);
        cpl = 2'd0;

        // R6 R9 exhaustive privilege sweep on global index 3
        for (int d = 0; d < 4; d++) begin
            put(0, 3, mk(32'h4000_0000 + 32'(d), 20'h000FF, 0, 1, 2'(d), 0));
            for (int c = 0; c < 4; c++) begin
                for (int r = 0; r < 4; r++) begin
                    cpl = 2'(c);
                    do_load(5, 16'h0018 | 16'(r));
                    expc = ((c > r ? c : r) > d) ? 3 : 0;
                    check($sformatf("R6 priv c%0d r%0d d%0d", c, r, d), {29'd0, r_cause}, 32'(expc));
                    if (expc == 0) begin
                        cpl = 2'd3;
                        if ((3 > r ? 3 : r) > d)
                            xlate(5, 32'h10, "R9 priv at use", 0, 3'd3, 32'h0);
                        else
                            xlate(5, 32'h10, "R9 priv at use", 1, 3'd0, 32'h4000_0010 + 32'(d));
                    end
                end
            end
        end
        cpl = 2'd0;

        // R11 stall during fetch
        put(0, 5, mk(32'h8000, 20'h00FFF, 0, 1, 2'd3, 0));
        @(negedge clk);
        ld_valid = 1; ld_seg = 2; ld_sel = 16'h0028;
        @(negedge clk);
        ld_valid = 0;
        check("R11 not ready", {31'd0, ld_ready}, 32'd0);
        xl_valid = 1; xl_seg = 2; xl_off = 0;
        #1;
        check("R11 stall same", {31'd0, xl_stall}, 32'd1);
        @(negedge clk);
        check("R11 no result", {30'd0, xl_ok, xl_fault}, 32'd0);
        xl_seg = 1; xl_off = 32'h10;
        #1;
        check("R11 other free", {31'd0, xl_stall}, 32'd0);
        @(negedge clk);
        xl_valid = 0;
        check("R11 other ok", {31'd0, xl_ok}, 32'd1);
        check("R11 other lin", xl_lin, 32'hFFFFF010);
        while (!ld_ready) @(negedge clk);
        xlate(2, 32'h20, "R11 after load", 1, 3'd0, 32'h8020);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule